// File: doc/BRIEF.md
# Card Clock Generator with Flow-Control Stall

This block derives the serial clock for a MultiMediaCard/SD host from the system master clock. A programmable divider sets the half-period of the card clock in whole master cycles. A power-saving mode stretches each half-period further by a power of two. Software programs the divider, the flow-control switches and two data-path mode bits through a single mode-register write port. While write protection is asserted, that port is locked.

During a data transfer, the block watches the transfer direction and the FIFO level flags. With read flow control on, it parks the card clock low while the receive FIFO is full. With write flow control on, it parks the card clock low while the transmit FIFO is empty. In both cases no data is lost; only bandwidth drops. With flow control off, the clock keeps running, and the block reports an overrun or underrun pulse at the edge where data would have been lost.

The block also drives a one-cycle strobe that marks the start of every high phase, so that the shifting logic can act in the master clock domain.

Top module: `cardClkGen`

## Requirements
- R1: With power save off, each card-clock half-period lasts CLKDIV+1 master cycles, so the period is 2*(CLKDIV+1); CLKDIV is mode-register bits [7:0].
- R2: With power save on, each half-period lasts (CLKDIV+1)*2^(PWSDIV+1) master cycles; PWSDIV is mode-register bits [10:8].
- R3: A power-save enable command (pwsCmdValid=1, pwsCmdOn=1) issued while PWSDIV is 0 leaves the mode unchanged and raises pwsReject for one cycle; pwsCmdOn=0 always turns power save off.
- R4: With read flow control on (bit 11), an active read transfer and rxFifoFull=1, the clock stays low past its due rising edge; it rises in the first cycle after the flag clears.
- R5: With write flow control on (bit 12), an active write transfer and txFifoEmpty=1, the clock likewise stays low until the flag clears.
- R6: With flow control off, the clock is not held. overrunStb (read, FIFO full) or underrunStb (write, FIFO empty) pulses in the first cycle of the high phase whose rising edge met the condition.
- R7: A mode-register write while wpEn=1 is dropped, and all fields keep their values.
- R8: forceByte follows bit 13 and padValue follows bit 14 of the last accepted mode-register write.
- R9: A stall can only extend a low phase; a high phase always lasts its full length.
- R10: A change to CLKDIV, PWSDIV or the power-save state takes effect from the next low phase; the phase in progress and the following high phase keep the old length.
- R11: After reset, the card clock is low, all strobes are low, every mode field is 0 and power save is off.
- R12: clkRiseStb is high exactly in the first master cycle of each high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Mode-register write strobe |
| regWrData | input | 15 | Mode-register write value |
| wpEn | input | 1 | Write-protect lock for the mode register |
| pwsCmdValid | input | 1 | Power-save command strobe |
| pwsCmdOn | input | 1 | Requested power-save state (1 = enable) |
| xferActive | input | 1 | A data transfer is in progress |
| xferRead | input | 1 | Transfer direction (1 = card to host) |
| rxFifoFull | input | 1 | Receive FIFO has no free space |
| txFifoEmpty | input | 1 | Transmit FIFO holds no data |
| cardClk | output | 1 | Card clock |
| clkRiseStb | output | 1 | First master cycle of a card-clock high phase |
| overrunStb | output | 1 | Read data lost at this edge |
| underrunStb | output | 1 | Write data missing at this edge |
| pwsReject | output | 1 | Power-save enable refused |
| forceByte | output | 1 | Byte-granular transfer mode to data path |
| padValue | output | 1 | Pad-value mode bit to data path |

## Verification
The bench targets the divider written halfway through a high phase. A design that reloads the length at once would shorten or stretch that pulse. It also holds the FIFO flag across several due rising edges and drops it in odd cycles. A design that stalls in the high phase, or resumes a cycle late, would shift every later edge. It sends the power-save command with a zero exponent, which a careless design would accept and divide by two. It also writes to the register while it is locked, which a weak lock would let through. Random traffic mixes proof modes, directions and flag patterns, so that missing or doubled overrun and underrun pulses show up against the reference model.

// File: rtl/ccgPkg.sv
package ccgPkg;

  // Strobes from the flow-control logic to the divider datapath
  typedef struct packed {
    logic holdLow;      // keep the clock low past a due rising edge
    logic flagOverrun;  // receive data would be lost at this edge
    logic flagUnderrun; // transmit data is missing at this edge
  } ctrlStbT;

endpackage

// File: rtl/ccgModeRegs.sv
module ccgModeRegs #(
  parameter int DIV_W = 8,
  parameter int PWS_W = 3,
  parameter int REG_W = DIV_W + PWS_W + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             wpEn,
  input  logic             pwsCmdValid,
  input  logic             pwsCmdOn,
  output logic [DIV_W-1:0] clkDiv,
  output logic [PWS_W-1:0] pwsDiv,
  output logic             rdProof,
  output logic             wrProof,
  output logic             forceByte,
  output logic             padValue,
  output logic             pwsOn,
  output logic             pwsReject
);

  localparam int PWS_LSB = DIV_W;
  localparam int RDP_BIT = DIV_W + PWS_W;
  localparam int WRP_BIT = RDP_BIT + 1;
  localparam int FB_BIT  = RDP_BIT + 2;
  localparam int PAD_BIT = RDP_BIT + 3;

  logic wrAccept;
  logic pwsZero;
  assign wrAccept = regWrEn && !wpEn;
  assign pwsZero  = (pwsDiv == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkDiv    <= '0;
      pwsDiv    <= '0;
      rdProof   <= 1'b0;
      wrProof   <= 1'b0;
      forceByte <= 1'b0;
      padValue  <= 1'b0;
    end else if (wrAccept) begin
      clkDiv    <= regWrData[DIV_W-1:0];
      pwsDiv    <= regWrData[PWS_LSB +: PWS_W];
      rdProof   <= regWrData[RDP_BIT];
      wrProof   <= regWrData[WRP_BIT];
      forceByte <= regWrData[FB_BIT];
      padValue  <= regWrData[PAD_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwsOn     <= 1'b0;
      pwsReject <= 1'b0;
    end else begin
      pwsReject <= pwsCmdValid && pwsCmdOn && pwsZero;
      if (pwsCmdValid) begin
        if (!pwsCmdOn)
          pwsOn <= 1'b0;
        else if (!pwsZero)
          pwsOn <= 1'b1;
      end
    end
  end

  AST_WP_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wpEn && regWrEn) |=> ($stable(clkDiv) && $stable(pwsDiv) && $stable(rdProof)
                           && $stable(wrProof) && $stable(forceByte) && $stable(padValue))); // R7

  AST_PWS_ZERO_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (pwsCmdValid && pwsCmdOn && pwsDiv == '0) |=> (pwsReject && $stable(pwsOn))); // R3

endmodule

// File: rtl/ccgCtrl.sv
module ccgCtrl
  import ccgPkg::*;
(
  input  logic    riseDue,
  input  logic    rdProof,
  input  logic    wrProof,
  input  logic    xferActive,
  input  logic    xferRead,
  input  logic    rxFifoFull,
  input  logic    txFifoEmpty,
  output ctrlStbT stb
);

  logic rdRisk;
  logic wrRisk;
  assign rdRisk = xferActive && xferRead && rxFifoFull;
  assign wrRisk = xferActive && !xferRead && txFifoEmpty;

  always_comb begin
    stb = '0;
    if (riseDue) begin
      stb.holdLow      = (rdRisk && rdProof) || (wrRisk && wrProof);
      stb.flagOverrun  = rdRisk && !rdProof;
      stb.flagUnderrun = wrRisk && !wrProof;
    end
  end

endmodule

// File: rtl/ccgDivider.sv
module ccgDivider
  import ccgPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PWS_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [PWS_W-1:0] pwsDiv,
  input  logic             pwsOn,
  input  ctrlStbT          stb,
  output logic             riseDue,
  output logic             cardClk,
  output logic             riseStb,
  output logic             overrunStb,
  output logic             underrunStb
);

  localparam int CNT_W = DIV_W + 1 + (1 << PWS_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfLat;
  logic [CNT_W-1:0] halfNext;
  logic [CNT_W-1:0] baseLen;
  logic [PWS_W:0]   shiftAmt;
  logic             clkQ;
  logic             atEnd;
  logic             fallDue;

  assign baseLen  = CNT_W'(clkDiv) + CNT_W'(1);
  assign shiftAmt = pwsOn ? ((PWS_W+1)'(pwsDiv) + (PWS_W+1)'(1)) : '0;
  assign halfNext = baseLen << shiftAmt;

  assign atEnd   = (cnt == halfLat - CNT_W'(1));
  assign riseDue = !clkQ && atEnd;
  assign fallDue = clkQ && atEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt         <= '0;
      halfLat     <= CNT_W'(1);
      clkQ        <= 1'b0;
      riseStb     <= 1'b0;
      overrunStb  <= 1'b0;
      underrunStb <= 1'b0;
    end else begin
      riseStb     <= riseDue && !stb.holdLow;
      overrunStb  <= stb.flagOverrun;
      underrunStb <= stb.flagUnderrun;
      if (riseDue) begin
        if (!stb.holdLow) begin
          clkQ <= 1'b1;
          cnt  <= '0;
        end
      end else if (fallDue) begin
        clkQ    <= 1'b0;
        cnt     <= '0;
        halfLat <= halfNext;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign cardClk = clkQ;

  AST_EDGE_AT_TERMINAL: assert property (@(posedge clk) disable iff (!rstN)
    (clkQ != $past(clkQ)) |-> $past(atEnd)); // R1

  AST_HOLD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.holdLow |=> !clkQ); // R4

  AST_HIGH_NOT_CUT: assert property (@(posedge clk) disable iff (!rstN)
    (clkQ && !atEnd) |=> clkQ); // R9

  AST_LEN_FIXED_IN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (clkQ && $past(clkQ)) |-> $stable(halfLat)); // R10

  AST_RISE_STB_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> (clkQ && !$past(clkQ))); // R12

endmodule

// File: rtl/cardClkGen.sv
module cardClkGen
  import ccgPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PWS_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [DIV_W+PWS_W+3:0]   regWrData,
  input  logic                     wpEn,
  input  logic                     pwsCmdValid,
  input  logic                     pwsCmdOn,
  input  logic                     xferActive,
  input  logic                     xferRead,
  input  logic                     rxFifoFull,
  input  logic                     txFifoEmpty,
  output logic                     cardClk,
  output logic                     clkRiseStb,
  output logic                     overrunStb,
  output logic                     underrunStb,
  output logic                     pwsReject,
  output logic                     forceByte,
  output logic                     padValue
);

  localparam int REG_W = DIV_W + PWS_W + 4;

  logic [DIV_W-1:0] clkDiv;
  logic [PWS_W-1:0] pwsDiv;
  logic             rdProof;
  logic             wrProof;
  logic             pwsOn;
  logic             riseDue;
  ctrlStbT          stb;

  ccgModeRegs #(.DIV_W(DIV_W), .PWS_W(PWS_W), .REG_W(REG_W)) uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .wpEn(wpEn), .pwsCmdValid(pwsCmdValid), .pwsCmdOn(pwsCmdOn),
    .clkDiv(clkDiv), .pwsDiv(pwsDiv), .rdProof(rdProof), .wrProof(wrProof),
    .forceByte(forceByte), .padValue(padValue), .pwsOn(pwsOn), .pwsReject(pwsReject)
  );

  ccgCtrl uCtrl (
    .riseDue(riseDue), .rdProof(rdProof), .wrProof(wrProof),
    .xferActive(xferActive), .xferRead(xferRead),
    .rxFifoFull(rxFifoFull), .txFifoEmpty(txFifoEmpty), .stb(stb)
  );

  ccgDivider #(.DIV_W(DIV_W), .PWS_W(PWS_W)) uDiv (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .pwsDiv(pwsDiv), .pwsOn(pwsOn),
    .stb(stb), .riseDue(riseDue), .cardClk(cardClk), .riseStb(clkRiseStb),
    .overrunStb(overrunStb), .underrunStb(underrunStb)
  );

endmodule

// File: tb/cardClkGen_test.sv
module cardClkGen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [14:0] regWrData = '0;
  logic        wpEn = 1'b0;
  logic        pwsCmdValid = 1'b0;
  logic        pwsCmdOn = 1'b0;
  logic        xferActive = 1'b0;
  logic        xferRead = 1'b0;
  logic        rxFifoFull = 1'b0;
  logic        txFifoEmpty = 1'b0;
  logic        cardClk, clkRiseStb, overrunStb, underrunStb, pwsReject, forceByte, padValue;

  always #2.5 clk = ~clk;

  cardClkGen uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData), .wpEn(wpEn),
    .pwsCmdValid(pwsCmdValid), .pwsCmdOn(pwsCmdOn), .xferActive(xferActive),
    .xferRead(xferRead), .rxFifoFull(rxFifoFull), .txFifoEmpty(txFifoEmpty),
    .cardClk(cardClk), .clkRiseStb(clkRiseStb), .overrunStb(overrunStb),
    .underrunStb(underrunStb), .pwsReject(pwsReject), .forceByte(forceByte),
    .padValue(padValue)
  );

  int    testsRun = 0;
  int    testsFailed = 0;
  int    cycles = 0;
  bit    finished = 0;
  bit    cmpOn = 0;
  string curReq = "R11";

  // reference model state
  int mDiv = 0, mPws = 0, mHalf = 1, mCnt = 0;
  bit mRdP = 0, mWrP = 0, mFb = 0, mPad = 0, mPwsOn = 0;
  bit mClk = 0, mRise = 0, mOver = 0, mUnder = 0, mRej = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mDiv = 0; mPws = 0; mHalf = 1; mCnt = 0;
      mRdP = 0; mWrP = 0; mFb = 0; mPad = 0; mPwsOn = 0;
      mClk = 0; mRise = 0; mOver = 0; mUnder = 0; mRej = 0;
    end else begin
      bit rdRisk, wrRisk, hold, due;
      rdRisk = xferActive && xferRead && rxFifoFull;
      wrRisk = xferActive && !xferRead && txFifoEmpty;
      hold   = (rdRisk && mRdP) || (wrRisk && mWrP);
      due    = (mCnt == mHalf - 1);
      mRise = 0; mOver = 0; mUnder = 0;
      if (!mClk && due) begin
        mOver  = rdRisk && !mRdP;
        mUnder = wrRisk && !mWrP;
        if (!hold) begin mClk = 1; mCnt = 0; mRise = 1; end
      end else if (mClk && due) begin
        mClk = 0; mCnt = 0;
        mHalf = (mDiv + 1) << (mPwsOn ? mPws + 1 : 0);
      end else begin
        mCnt++;
      end
      mRej = pwsCmdValid && pwsCmdOn && (mPws == 0);
      if (pwsCmdValid) begin
        if (!pwsCmdOn) mPwsOn = 0;
        else if (mPws != 0) mPwsOn = 1;
      end
      if (regWrEn && !wpEn) begin
        mDiv = int'(regWrData[7:0]); mPws = int'(regWrData[10:8]);
        mRdP = regWrData[11]; mWrP = regWrData[12];
        mFb = regWrData[13]; mPad = regWrData[14];
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      logic [6:0] act, exp;
      act = {cardClk, clkRiseStb, overrunStb, underrunStb, pwsReject, forceByte, padValue};
      exp = {mClk, mRise, mOver, mUnder, mRej, mFb, mPad};
      check(act === exp, curReq, "outputs {clk,rise,ovr,und,rej,fb,pad}", int'(act), int'(exp));
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      finish();
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeMode(input int dv, input int pw, input bit rd, input bit wr,
                           input bit fb, input bit pad);
    regWrData = {pad, fb, wr, rd, 3'(pw), 8'(dv)};
    regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic pwsCmd(input bit on);
    pwsCmdValid = 1'b1; pwsCmdOn = on;
    tick();
    pwsCmdValid = 1'b0;
  endtask

  // count master cycles between two consecutive rising strobes
  task automatic measure(input int expPeriod, input string req);
    int n = 0;
    while (!clkRiseStb) tick();
    tick();
    n = 1;
    while (!clkRiseStb && n < 5000) begin tick(); n++; end
    check(n == expPeriod, req, "card clock period", n, expPeriod);
  endtask

  initial begin
    tick(3);
    check(cardClk === 1'b0 && clkRiseStb === 1'b0 && forceByte === 1'b0 && pwsReject === 1'b0,
          "R11", "reset outputs", int'(cardClk), 0);
    rstN = 1'b1;
    cmpOn = 1;

    curReq = "R1"; measure(2, "R1");
    writeMode(2, 0, 0, 0, 0, 0); tick(12);
    measure(6, "R1");
    curReq = "R10";
    while (!clkRiseStb) tick();
    tick();
    writeMode(4, 0, 0, 0, 0, 0);  // written inside a high phase
    tick(30);
    measure(10, "R10");

    curReq = "R3";
    writeMode(1, 0, 0, 0, 0, 0); tick(8);
    pwsCmd(1'b1);
    check(pwsReject === 1'b1, "R3", "reject pulse", int'(pwsReject), 1);
    tick(10);
    measure(4, "R3");
    curReq = "R2";
    writeMode(1, 1, 0, 0, 0, 0);
    pwsCmd(1'b1); tick(40);
    measure(16, "R2");
    pwsCmd(1'b0); tick(40);
    measure(4, "R2");

    curReq = "R8";
    writeMode(0, 0, 0, 0, 1, 1); tick(2);
    check(forceByte === 1'b1 && padValue === 1'b1, "R8", "mode bits", int'({forceByte, padValue}), 3);
    curReq = "R7";
    wpEn = 1'b1;
    writeMode(5, 2, 1, 1, 0, 0); tick(2);
    check(forceByte === 1'b1 && padValue === 1'b1, "R7", "locked mode bits", int'({forceByte, padValue}), 3);
    measure(2, "R7");
    wpEn = 1'b0;

    curReq = "R4";
    writeMode(1, 0, 1, 0, 0, 0); tick(6);
    xferActive = 1'b1; xferRead = 1'b1; rxFifoFull = 1'b1;
    tick(25);
    check(cardClk === 1'b0, "R4", "clock parked low", int'(cardClk), 0);
    rxFifoFull = 1'b0; tick(8);
    measure(4, "R4");

    curReq = "R5";
    writeMode(2, 0, 0, 1, 0, 0); tick(8);
    xferRead = 1'b0; txFifoEmpty = 1'b1;
    tick(25);
    check(cardClk === 1'b0, "R5", "clock parked low", int'(cardClk), 0);
    txFifoEmpty = 1'b0; tick(3);

    curReq = "R6";
    writeMode(1, 0, 0, 0, 0, 0); tick(4);
    txFifoEmpty = 1'b1; tick(20);
    txFifoEmpty = 1'b0; xferRead = 1'b1; rxFifoFull = 1'b1; tick(20);
    measure(4, "R6");
    rxFifoFull = 1'b0;

    curReq = "R9";
    for (int k = 0; k < 4000; k++) begin
      xferActive  = ($urandom_range(0, 3) != 0);
      xferRead    = $urandom_range(0, 1);
      rxFifoFull  = ($urandom_range(0, 2) == 0);
      txFifoEmpty = ($urandom_range(0, 2) == 0);
      wpEn        = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 40) == 0) begin
        regWrData = 15'($urandom_range(0, 32767)) & 15'h7B03;
        regWrEn = 1'b1;
      end else regWrEn = 1'b0;
      if ($urandom_range(0, 60) == 0) begin
        pwsCmdValid = 1'b1; pwsCmdOn = $urandom_range(0, 1);
      end else pwsCmdValid = 1'b0;
      tick();
    end
    regWrEn = 1'b0; pwsCmdValid = 1'b0; tick(2);
    finish();
  end

endmodule